// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets each core of a small multi-core cluster interrupt any other core and hand it a 16-bit message in the same step. Every core has a pair of 32-bit registers on a simple register bus: a control word that the core writes, and a status word that the core reads. One write to the sender's control word picks the target core, stores the sender's number and the payload in the target's status word, and raises the target's interrupt line. The target reads its status word to learn the sender and the payload. It then writes its own control word with the acknowledge bit set, which clears the pending flag and drops its interrupt line.

The bus takes one access per cycle with no wait states. Read data is registered and appears in the cycle after the read address. It shows the register contents from before any write made in that same cycle. Each core has one level interrupt output.

Top module: `ipi_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every control and status register reads as zero, every interrupt output is low and the read data is zero.
- R2: A bus write to a core's control register stores all 32 bits. A later read of that register returns the stored value.
- R3: Address bit 2 selects the control word (0) or the status word (1). Address bits from bit 3 upward give the core index, and bits 1:0 are ignored. Read data is valid in the cycle after the address is presented.
- R4: A control write from core S with bit 30 set and bits 29:16 holding an in-range destination D sets status[D] to: bit 31 zero, bit 30 (pending) one, bits 29:16 equal to S, and bits 15:0 equal to bits 15:0 of the written word. This replaces any earlier contents. Interrupt output D is high from the next cycle.
- R5: A control write from core S with bit 31 set clears bit 30 of status[S], leaves its other bits unchanged and drives interrupt output S low from the next cycle.
- R6: When bits 30 and 31 are both set, generation happens first and acknowledge second. A core that messages itself in the same write ends with its pending flag clear, with the new sender and payload fields. A core that messages another core sets that core pending and clears its own pending flag.
- R7: Writes to a status register address change no register and no interrupt output.
- R8: Each interrupt output equals bit 30 of its core's status register in every cycle.
- R9: A generate request whose destination is at or above the configured core count changes no status register and no interrupt output. The control word is still stored.
- R10: An access to a core index at or above the configured core count reads as zero, and a write to such an index has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | NUM_CORES | Level interrupt, one per core |

## Verification
The hardest cases to reach are the combined generate-and-acknowledge writes, above all a core that messages itself while it acknowledges. Here the order of the two effects decides whether the line stays high. The bench sweeps every sender, every destination in range and out of range, and all four settings of the two command bits. It starts from the state that the earlier steps of the sweep left behind, so pending flags from earlier messages are present when the later writes land. After each write it reads every address in the window, including the unconfigured indices, and compares each read and the interrupt vector with an arithmetic model.

// File: rtl/ipi_pkg.sv
// Shared constants and helpers for the inter-processor interrupt mailbox.
// Assumes 32-bit registers and at most four cores.
package ipi_pkg;
    localparam int MAX_CORES = 4;
    localparam int WORD_W    = 32;
    localparam int ACK_BIT   = 31;
    localparam int GEN_BIT   = 30;
    localparam int PEND_BIT  = 30;
    localparam int ID_LSB    = 16;
    localparam int ID_W      = 14;
    localparam int PAY_W     = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ID_W-1:0]   core_id_t;
    typedef logic [PAY_W-1:0]  payload_t;

    // Build the status word a destination core receives.
    function automatic word_t make_status(core_id_t src, payload_t pay);
        return {1'b0, 1'b1, src, pay};
    endfunction
endpackage

// File: rtl/ipi_decode.sv
// Bus write decoder. It turns one register-bus write into per-core strobes:
// a control store, an acknowledge and a generate hit. It also gives the
// sender index and the payload.
// Assumes one access per cycle. Indices at or above NUM_CORES decode to nothing.
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 5,
    localparam int IDX_W    = ADDR_W - 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  word_t                wdata_i,
    output logic [NUM_CORES-1:0] ctrl_wr_o,
    output logic [NUM_CORES-1:0] ack_o,
    output logic [NUM_CORES-1:0] gen_o,
    output core_id_t             src_id_o,
    output payload_t             payload_o
);
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic             ctrl_any;
    core_id_t         dst;
    logic             unused_low;

    assign idx        = addr_i[ADDR_W-1:3];
    assign unused_low = ^addr_i[1:0];
    assign dst        = wdata_i[ID_LSB +: ID_W];

    // Decide whether the access targets a configured core's control word.
    always_comb begin
        idx_ok   = int'(idx) < NUM_CORES;
        ctrl_any = we_i && idx_ok && !addr_i[2];
    end

    assign src_id_o  = core_id_t'(idx);
    assign payload_o = wdata_i[PAY_W-1:0];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // Per-core strobes: store, acknowledge and generate hit.
        assign ctrl_wr_o[c] = ctrl_any && (idx == IDX_W'(c));
        assign ack_o[c]     = ctrl_wr_o[c] && wdata_i[ACK_BIT];
        assign gen_o[c]     = ctrl_any && wdata_i[GEN_BIT] && (dst == core_id_t'(c));
    end

    // At most one destination per write (R9).
    p_gen_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gen_o));
    // A generate hit only comes from an in-range destination (R9).
    p_gen_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_o != '0) |-> (int'(dst) < NUM_CORES));
    // Status addresses and unconfigured indices never strobe a core (R7, R10).
    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i[2] || int'(idx) >= NUM_CORES) |-> (ctrl_wr_o == '0 && gen_o == '0));
endmodule

// File: rtl/ipi_core_slot.sv
// State for one core: its control word and its status word, with the
// pending flag that drives the core's interrupt line.
// Assumes the decoder asserts at most one strobe set per cycle. Generation is
// applied before acknowledge when both arrive together.
module ipi_core_slot
    import ipi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr_i,
    input  logic     ack_i,
    input  logic     gen_i,
    input  word_t    wdata_i,
    input  core_id_t src_id_i,
    input  payload_t payload_i,
    output word_t    ctrl_o,
    output word_t    status_o,
    output logic     irq_o
);
    word_t ctrl_q;
    word_t status_q;
    word_t status_nx;

    // Next status: generation overwrites first, then acknowledge clears pending.
    always_comb begin
        status_nx = status_q;
        if (gen_i) status_nx = make_status(src_id_i, payload_i);
        if (ack_i) status_nx[PEND_BIT] = 1'b0;
    end

    // Register the control and status words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            status_q <= '0;
        end else begin
            if (ctrl_wr_i) ctrl_q <= wdata_i;
            status_q <= status_nx;
        end
    end

    assign ctrl_o   = ctrl_q;
    assign status_o = status_q;
    assign irq_o    = status_q[PEND_BIT];

    // A control write is stored in full (R2).
    p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i |=> ctrl_q == $past(wdata_i));
    // Without a write the control word holds (R2).
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_i |=> $stable(ctrl_q));
    // A generate without acknowledge leaves the line pending with sender and payload (R4).
    p_gen_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_i && !ack_i) |=> (irq_o && status_q[ID_LSB +: ID_W] == $past(src_id_i)
                               && status_q[PAY_W-1:0] == $past(payload_i)));
    // An acknowledge always ends with the line low, even with a self message (R5, R6).
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !irq_o);
    // Status changes only through a generate or an acknowledge (R7).
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_i && !ack_i) |=> $stable(status_q));
endmodule

// File: rtl/ipi_mailbox.sv
// Inter-processor interrupt mailbox top. It holds one control/status pair per
// core at 8 bytes per core and gives a registered read port and one level
// interrupt per core.
// Assumes NUM_CORES <= 4 and an address wide enough for the window.
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] irq_o
);
    localparam int IDX_W = ADDR_W - 3;

    if (NUM_CORES < 1 || NUM_CORES > MAX_CORES || (1 << IDX_W) < NUM_CORES) begin : g_bad_cfg
        $error("ipi_mailbox: unsupported NUM_CORES/ADDR_W");
    end

    logic [NUM_CORES-1:0] ctrl_wr;
    logic [NUM_CORES-1:0] ack;
    logic [NUM_CORES-1:0] gen;
    core_id_t             src_id;
    payload_t             payload;
    word_t                ctrl_w [NUM_CORES];
    word_t                stat_w [NUM_CORES];
    word_t                rd_nx;
    word_t                rdata_q;
    logic [IDX_W-1:0]     rd_idx;

    ipi_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .we_i      (bus_we),
        .wdata_i   (bus_wdata),
        .ctrl_wr_o (ctrl_wr),
        .ack_o     (ack),
        .gen_o     (gen),
        .src_id_o  (src_id),
        .payload_o (payload)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
        ipi_core_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_wr_i (ctrl_wr[c]),
            .ack_i     (ack[c]),
            .gen_i     (gen[c]),
            .wdata_i   (bus_wdata),
            .src_id_i  (src_id),
            .payload_i (payload),
            .ctrl_o    (ctrl_w[c]),
            .status_o  (stat_w[c]),
            .irq_o     (irq_o[c])
        );
    end

    assign rd_idx = bus_addr[ADDR_W-1:3];

    // Select the addressed word; unconfigured indices read zero.
    always_comb begin
        rd_nx = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (rd_idx == IDX_W'(c)) rd_nx = bus_addr[2] ? stat_w[c] : ctrl_w[c];
        end
    end

    // Register read data for the cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_nx;
    end

    assign bus_rdata = rdata_q;

    // Unconfigured indices read as zero one cycle later (R10).
    p_oob_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_idx) >= NUM_CORES) |=> bus_rdata == '0);
    // Right after reset no interrupt is raised (R1).
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0 && bus_rdata == '0));
endmodule

// File: tb/tb_ipi_mailbox.sv
// Sweep bench for ipi_mailbox with four cores and room for four unconfigured indices.
module tb_ipi_mailbox;
    localparam int N  = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] m_ctrl [N];
    logic [31:0] m_stat [N];

    ipi_mailbox #(.NUM_CORES(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of a control/status write from the requirements.
    task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
        int idx = int'(a[AW-1:3]);
        int dst = int'(d[29:16]);
        if (idx < N && !a[2]) begin
            m_ctrl[idx] = d;
            if (d[30] && dst < N) m_stat[dst] = {2'b01, 14'(idx), d[15:0]};
            if (d[31]) m_stat[idx][30] = 1'b0;
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    // Read every word of the window and the interrupt vector.
    task automatic verify_all(string tag);
        logic [31:0] got;
        logic [31:0] exp;
        logic [N-1:0] irq_exp;
        for (int c = 0; c < N; c++) irq_exp[c] = m_stat[c][30];
        check({tag, " R8 irq"}, 32'(irq_o), 32'(irq_exp));
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 2; s++) begin
                bus_read({3'(i), 1'(s), 2'(i + s)}, got);
                exp = (i < N) ? (s == 1 ? m_stat[i] : m_ctrl[i]) : 32'h0;
                check({tag, (i < N) ? " R3 word" : " R10 oob read"}, got, exp);
            end
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] got;
        for (int c = 0; c < N; c++) begin m_ctrl[c] = '0; m_stat[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata after reset", bus_rdata, 32'h0);
        check("R1 irq after reset", 32'(irq_o), 32'h0);
        verify_all("R1");

        // Read latency: data present exactly one cycle after the address.
        bus_write(6'b000_0_00, 32'h1234_5678);
        @(negedge clk); bus_addr = 6'b000_0_11;
        @(negedge clk); check("R2 R3 read next cycle", bus_rdata, 32'h1234_5678);

        // Sweep senders, destinations and the two command bits (R4, R5, R6, R9).
        for (int src = 0; src < N; src++) begin
            for (int dst = 0; dst < 8; dst++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    d = {mode[1], mode[0], 14'(dst), 16'((src * 4099 + dst * 257 + mode * 31) ^ 16'hA5C3)};
                    bus_write({3'(src), 1'b0, 2'(mode)}, d);
                    verify_all(mode == 3 ? "R6 gen+ack" : mode == 2 ? "R5 ack"
                               : (dst >= N ? "R9 bad dest" : "R4 gen"));
                end
            end
        end

        // Self message with acknowledge must end clear, with the new fields (R6).
        bus_write(6'b010_0_00, 32'h4002_0001);
        check("R6 self pending set", 32'(irq_o[2]), 32'h1);
        bus_write(6'b010_0_00, 32'hC002_BEEF);
        bus_read(6'b010_1_00, got);
        check("R6 self gen+ack status", got, 32'h0002_BEEF);
        check("R6 self gen+ack irq", 32'(irq_o[2]), 32'h0);

        // Status writes are ignored (R7).
        bus_write(6'b001_0_00, 32'h4000_5555);
        for (int c = 0; c < N; c++) begin
            bus_write({3'(c), 1'b1, 2'b00}, 32'hC001_FFFF);
            verify_all("R7 status write");
        end

        // Writes to unconfigured indices are ignored (R10).
        for (int c = N; c < 8; c++) begin
            bus_write({3'(c), 1'b0, 2'b01}, 32'h4000_0ABC);
            verify_all("R10 oob write");
        end

        summary();
        $finish;
    end
endmodule